// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block is the digital control for a counting single-slope converter. A free-running count marks out a fixed conversion frame. In the first cycle of each frame the block asks the analog side to discharge its ramp. The block then waits for the comparator to report that the ramp has climbed past the selected input, and it freezes the count at that moment. At the end of the frame the frozen count becomes the output code, and a one-cycle strobe announces it.

The block also sets the controls for the analog front end. The input-select and sample-and-hold bypass requests are taken once per frame, at the frame boundary, so a conversion never changes channel or sampling mode partway through. While sampling is enabled, the hold command is released during ramp discharge so that the input is tracked then, and it is held for the rest of the frame. The comparator arrives asynchronously. It passes through a synchroniser before its first rising edge is searched for, and its synchronised level is brought out for observation together with the ramp-discharge signal.

Top module: `ssadc_seq`

## Requirements
- R1: A frame lasts exactly 256 clock cycles. The internal count runs 0 to 255 and then wraps to 0, and `valid_o` rises exactly once in every 256 cycles.
- R2: `ramp_rst_o` is high in the first cycle of each frame (count 0) and low in every other cycle.
- R3: `cmp_i` passes through two flip-flops. The code of a frame is the count in the first cycle in which the synchronised comparator reads high after having read low in that frame. A rise of `cmp_i` driven during the cycle with count p therefore yields code p+2.
- R4: Once a frame has captured a value, any later fall and rise of the comparator within the same frame leaves that frame's code unchanged.
- R5: A frame in which no synchronised rising edge occurs produces code 255 (full scale).
- R6: `code_o` keeps its value except at the clock edge that ends a frame. At that edge it takes the frame's code, and `valid_o` is high for exactly the following cycle (count 0). No strobe follows the partial time before the first frame boundary after reset.
- R7: An asynchronous active-low `rst_n` clears the count, `code_o`, `valid_o` and the latched select and bypass bits, with no clock edge needed. After reset `ramp_rst_o` therefore reads high.
- R8: `ch_sel_o` and `sh_bypass_o` take the values of `ch_sel_i` and `sh_bypass_i` present in the last cycle (count 255) of the previous frame, and stay constant for the whole frame. For `ch_sel_o`, 0 selects input 0 and 1 selects input 1. Both read 0 in the first frame after reset.
- R9: `sh_hold_o` is high when the latched bypass bit is 0 and the count is not 0. It is low during ramp discharge and low throughout any frame in which the latched bypass bit is 1.
- R10: `cmp_obs_o` equals `cmp_i` delayed by two clock cycles (the synchronised level), and `spare_o` is all ones at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_sel_i | input | 1 | Requested analog channel for the next frame |
| sh_bypass_i | input | 1 | Requested sample-and-hold bypass for the next frame |
| cmp_i | input | 1 | Asynchronous comparator output, high when the ramp is above the input |
| code_o | output | 8 | Most recent conversion code |
| valid_o | output | 1 | One-cycle strobe marking a new code |
| cmp_obs_o | output | 1 | Synchronised comparator level, for observation |
| ramp_rst_o | output | 1 | Ramp discharge command |
| ch_sel_o | output | 1 | Channel select sent to the analog multiplexer |
| sh_bypass_o | output | 1 | Bypass command sent to the sample-and-hold |
| sh_hold_o | output | 1 | Hold command sent to the sample-and-hold (low means track) |
| spare_o | output | 5 | Unused outputs, tied high |

## Verification
A count that slips or wraps at the wrong value moves the ramp-discharge pulse and the strobe away from their 256-cycle spacing. This shows on the next frame boundary. A capture flag that is not cleared at the boundary, or not set on the first edge, produces a wrong code. The error appears at the strobe that ends the affected frame, which is at most 256 cycles later. A glitch placed after the crossing shows whether later edges are ignored. A select or bypass latch that samples at the wrong time shows at once on `ch_sel_o`, `sh_bypass_o` or `sh_hold_o` in the middle of a frame, and through the comparator model it also produces the wrong code one frame later.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  localparam int CODE_W     = 8;
  localparam int SYNC_DEPTH = 2;
  localparam int SPARE_W    = 5;

  typedef struct packed {
    logic sel;
    logic byp;
  } front_ctl_t;
endpackage

// File: rtl/ssadc_frame_ctr.sv
module ssadc_frame_ctr #(
  parameter int W = ssadc_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         byp_i,
  output logic [W-1:0] cnt_o,
  output logic         first_o,
  output logic         last_o,
  output logic         sel_o,
  output logic         byp_o
);
  localparam logic [W-1:0] LAST_CNT = '1;

  ssadc_pkg::front_ctl_t ctl_q;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c);
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= next_count(cnt_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (last_o) ctl_q <= '{sel: sel_i, byp: byp_i};
  end

  assign first_o = (cnt_o == '0);
  assign last_o  = (cnt_o == LAST_CNT);
  assign sel_o   = ctl_q.sel;
  assign byp_o   = ctl_q.byp;

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> first_o);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_o |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R8
  ctl_frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_o |-> ($stable(sel_o) && $stable(byp_o)));
endmodule

// File: rtl/ssadc_cmp_sync.sv
module ssadc_cmp_sync #(
  parameter int DEPTH = ssadc_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [DEPTH-1:0] chain_q;
  logic             prev_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[DEPTH-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[DEPTH-1];
  end

  assign level_o = chain_q[DEPTH-1];
  assign rise_o  = level_o & ~prev_q;

  // R3
  rise_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ssadc_capture.sv
module ssadc_capture #(
  parameter int W = ssadc_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         first_i,
  input  logic         last_i,
  input  logic         rise_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);
  logic         got_q;
  logic [W-1:0] held_q;

  function automatic logic [W-1:0] frame_code(input logic hit, input logic [W-1:0] held);
    return hit ? held : {W{1'b1}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q  <= 1'b0;
      held_q <= '0;
    end else if (last_i) begin
      got_q  <= 1'b0;
    end else if (rise_i && !got_q) begin
      got_q  <= 1'b1;
      held_q <= cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_i;
      if (last_i) code_o <= frame_code(got_q, held_q);
    end
  end

  // R3
  first_edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !got_q && !last_i) |=> (got_q && held_q == $past(cnt_i)));
  // R4
  later_edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q && !last_i) |=> $stable(held_q));
  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(code_o));
  // R6
  valid_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R1
  valid_at_frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> first_i);
endmodule

// File: rtl/ssadc_seq.sv
module ssadc_seq #(
  parameter int CODE_W     = ssadc_pkg::CODE_W,
  parameter int SYNC_DEPTH = ssadc_pkg::SYNC_DEPTH,
  parameter int SPARE_W    = ssadc_pkg::SPARE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_sel_i,
  input  logic              sh_bypass_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              cmp_obs_o,
  output logic              ramp_rst_o,
  output logic              ch_sel_o,
  output logic              sh_bypass_o,
  output logic              sh_hold_o,
  output logic [SPARE_W-1:0] spare_o
);
  logic [CODE_W-1:0] frame_cnt;
  logic              frame_first;
  logic              frame_last;
  logic              cmp_level;
  logic              cmp_rise;

  ssadc_frame_ctr #(.W(CODE_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (ch_sel_i),
    .byp_i   (sh_bypass_i),
    .cnt_o   (frame_cnt),
    .first_o (frame_first),
    .last_o  (frame_last),
    .sel_o   (ch_sel_o),
    .byp_o   (sh_bypass_o)
  );

  ssadc_cmp_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_i),
    .level_o (cmp_level),
    .rise_o  (cmp_rise)
  );

  ssadc_capture #(.W(CODE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_i   (frame_cnt),
    .first_i (frame_first),
    .last_i  (frame_last),
    .rise_i  (cmp_rise),
    .code_o  (code_o),
    .valid_o (valid_o)
  );

  assign ramp_rst_o = frame_first;
  assign sh_hold_o  = ~sh_bypass_o & ~frame_first;
  assign cmp_obs_o  = cmp_level;
  assign spare_o    = '1;

  // R9
  hold_only_when_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_hold_o |-> (!sh_bypass_o && !ramp_rst_o));
  // R2
  ramp_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst_o |=> !ramp_rst_o);
endmodule

// File: tb/ssadc_seq_test.sv
module ssadc_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ch_sel_i = 1'b0;
  logic       sh_bypass_i = 1'b0;
  logic       cmp_i = 1'b0;
  logic [7:0] code_o;
  logic       valid_o, cmp_obs_o, ramp_rst_o, ch_sel_o, sh_bypass_o, sh_hold_o;
  logic [4:0] spare_o;

  ssadc_seq uut (
    .clk(clk), .rst_n(rst_n), .ch_sel_i(ch_sel_i), .sh_bypass_i(sh_bypass_i),
    .cmp_i(cmp_i), .code_o(code_o), .valid_o(valid_o), .cmp_obs_o(cmp_obs_o),
    .ramp_rst_o(ramp_rst_o), .ch_sel_o(ch_sel_o), .sh_bypass_o(sh_bypass_o),
    .sh_hold_o(sh_hold_o), .spare_o(spare_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  int pos = 0;
  int frame = 0;
  int last_code = 0;
  bit h1 = 0, h2 = 0;

  int    th0_a [9] = '{50, 7, 9, 253, 999, 80, 33, 10, 40};
  int    th1_a [9] = '{77, 120, 1, 5, 6, 7, 200, 99, 40};
  bit    sel_a [9] = '{0, 1, 1, 0, 0, 0, 1, 0, 0};
  bit    byp_a [9] = '{0, 0, 1, 1, 0, 0, 0, 0, 0};
  bit    glt_a [9] = '{0, 0, 0, 0, 0, 1, 1, 0, 0};
  string tag_a [9] = '{"R3", "R8", "R3", "R3", "R5", "R4", "R4", "R3", "R3"};

  int    exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (frame %0d pos %0d)", req, act, exp, frame, pos);
    end
  endtask

  // Driver side of the scoreboard: expected code for a frame from its own threshold.
  task automatic push_expected(input int f);
    int thr;
    int code;
    thr  = sel_a[f] ? th1_a[f] : th0_a[f];
    code = (thr + 2 > 255) ? 255 : thr + 2;
    exp_q.push_back(code);
    tag_q.push_back(tag_a[f]);
  endtask

  always @(negedge clk) begin
    if (running) begin
      int thr;
      bit c;
      bit exp_valid;
      // Monitor side
      exp_valid = (pos == 0) && (frame > 0);
      chk(valid_o == exp_valid, "R6 valid", valid_o, exp_valid);
      if (valid_o && exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(code_o == e, t, code_o, e);
        last_code = code_o;
      end else begin
        chk(code_o == last_code, "R6 hold", code_o, last_code);
      end
      chk(ramp_rst_o == (pos == 0), "R2", ramp_rst_o, pos == 0);
      chk(ch_sel_o == sel_a[frame], "R8 sel", ch_sel_o, sel_a[frame]);
      chk(sh_bypass_o == byp_a[frame], "R8 byp", sh_bypass_o, byp_a[frame]);
      chk(sh_hold_o == (!byp_a[frame] && pos != 0), "R9", sh_hold_o, !byp_a[frame] && pos != 0);
      chk(cmp_obs_o == h2, "R10 obs", cmp_obs_o, h2);
      chk(spare_o == 5'h1f, "R10 spare", spare_o, 5'h1f);
      if (pos == 0) push_expected(frame);
      // Analog model: ramp against the input the design actually selects
      thr = ch_sel_o ? th1_a[frame] : th0_a[frame];
      c = (pos >= thr);
      if (glt_a[frame] && pos == thr + 5) c = 1'b0;
      cmp_i = c;
      h2 = h1;
      h1 = c;
      if (pos == 100 && frame < 8) begin
        ch_sel_i    = sel_a[frame + 1];
        sh_bypass_i = byp_a[frame + 1];
      end
      pos++;
      if (pos == 256) begin
        pos = 0;
        frame++;
      end
      if (frame == 8 && pos == 60) running = 0;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(code_o == 0, "R7 code", code_o, 0);
    chk(valid_o == 0, "R7 valid", valid_o, 0);
    chk(ramp_rst_o == 1, "R7 count", ramp_rst_o, 1);
    chk(ch_sel_o == 0 && sh_bypass_o == 0, "R7 ctl", {ch_sel_o, sh_bypass_o}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    running = 1;
    wait (running == 0);
    @(negedge clk);
    #2;
    chk(code_o == 12, "R6 before reset", code_o, 12);
    rst_n = 1'b0;
    #1;
    // R7 asynchronous clear without a clock edge
    chk(code_o == 0, "R7 async code", code_o, 0);
    chk(valid_o == 0, "R7 async valid", valid_o, 0);
    chk(ramp_rst_o == 1, "R7 async count", ramp_rst_o, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule